// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiplier

This block multiplies two square N×N matrices of signed two's-complement integers on a clocked mesh of multiply-accumulate cells. Each cell keeps one element of the product C = A×B in a local accumulator.

A pulse on `start` loads both operand matrices in parallel into counter-driven edge sequencers. There is one sequencer per row of A on the left edge and one per column of B on the top edge. Each sequencer emits its lane with a skew equal to its lane index and pads with zeros on every other cycle. A values move one cell right per clock and B values move one cell down per clock, so matching terms meet in the cell that owns them.

After 3N−2 accumulate cycles the cells switch to pass-through. The stored sums shift down the columns and leave the bottom edge one row per cycle, each row marked by `res_valid`. A single-cycle `done` pulse follows the last row. The block then accepts the next `start`.

Top module: `sa_matmul`

## Requirements
- R1: While reset is asserted and in the first idle cycle after it, `res_valid` and `done` are low and `res_row` is all zero.
- R2: Operand element A[i][k] is the signed W-bit field at bit (i·N+k)·W of `a_flat`, and B[k][j] is the field at bit (k·N+j)·W of `b_flat`. Each drained element C[i][j] equals the exact signed sum over k of A[i][k]·B[k][j]. It is carried in ACC_W = 2W+⌈log2 N⌉ bits, and element j of a row occupies bits j·ACC_W upward of `res_row`.
- R3: If `start` is accepted at clock edge 0, `res_valid` first goes high after edge 3N−2.
- R4: `res_valid` stays high for exactly N consecutive cycles. The rows appear bottom first: C row N−1 in the first valid cycle, then row N−2, and so on down to row 0.
- R5: `done` is high for exactly one cycle, the cycle right after the last valid row. `res_valid` is low in that cycle and in the next one.
- R6: Every accepted `start` clears all accumulators, so a result never depends on a previous multiplication.
- R7: A `start` pulse that arrives while a multiplication, drain or `done` cycle is in progress is ignored. It changes neither the results nor the timing of the current run.
- R8: The operand inputs are sampled only on the edge that accepts `start`. Later changes to `a_flat` or `b_flat` have no effect on the current results.
- R9: Extreme operands are exact. With every element at −2^(W−1) on both sides, each result is N·2^(2W−2). With A at 2^(W−1)−1 and B at −2^(W−1), each result is −N·(2^(W−1)−1)·2^(W−1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a multiplication; honoured only when idle |
| a_flat | input | N·N·W | Left operand, row-major, signed elements |
| b_flat | input | N·N·W | Right operand, row-major, signed elements |
| res_row | output | N·ACC_W | One drained result row, element j at bits j·ACC_W |
| res_valid | output | 1 | `res_row` holds a product row |
| done | output | 1 | One-cycle pulse after the last row |

## Verification
With the accepting edge counted as edge 0, a correct run raises `res_valid` after edge 3N−2. The valid window then stays open for N cycles, row N−1 first, and `done` follows after edge 4N−2. The bench drives inputs on falling edges. After each rising edge it samples on the next falling edge, keeps a count of the rising edges since the accepting one, and derives from that count which row, if any, must be present and whether `done` is due. Every product row is compared with a software product computed from the row-major fields. Valid and done are checked in every cycle of the window, so an early, late or stretched output is caught as well as a wrong value.

// File: rtl/sa_pkg.sv
package sa_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_CALC  = 2'd1,
        PH_DRAIN = 2'd2,
        PH_DONE  = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_CLEAR = 2'd1,
        OP_MAC   = 2'd2,
        OP_SHIFT = 2'd3
    } cell_op_e;

endpackage

// File: rtl/sa_feeder.sv
// Edge sequencer: stores one lane of an operand and emits element k when the
// step counter equals LANE + k, zero on every other step.
module sa_feeder #(
    parameter int N     = 4,
    parameter int W     = 8,
    parameter int LANE  = 0,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [N*W-1:0]   vec_in,
    input  logic [CNT_W-1:0] step,
    output logic [W-1:0]     lane_out
);

    logic [N*W-1:0] vals_d, vals_q;

    always_comb begin
        vals_d   = vals_q;
        lane_out = '0;
        if (load) begin
            vals_d = vec_in;
        end
        for (int k = 0; k < N; k++) begin
            if (step == CNT_W'(LANE + k)) begin
                lane_out = vals_q[k*W +: W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vals_q <= '0;
        end else begin
            vals_q <= vals_d;
        end
    end

endmodule

// File: rtl/sa_cell.sv
// One mesh cell: forwards A right and B down, accumulates their product,
// or passes the accumulator from the cell above during drain.
module sa_cell
    import sa_pkg::*;
#(
    parameter int W     = 8,
    parameter int ACC_W = 18
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  cell_op_e                op,
    input  logic signed [W-1:0]     a_in,
    input  logic signed [W-1:0]     b_in,
    input  logic signed [ACC_W-1:0] acc_in,
    output logic signed [W-1:0]     a_out,
    output logic signed [W-1:0]     b_out,
    output logic signed [ACC_W-1:0] acc_out
);

    typedef struct packed {
        logic signed [W-1:0]     a;
        logic signed [W-1:0]     b;
        logic signed [ACC_W-1:0] acc;
    } cell_t;

    cell_t                   cell_d, cell_q;
    logic signed [2*W-1:0]   prod;

    always_comb begin
        cell_d = cell_q;
        prod   = a_in * b_in;
        unique case (op)
            OP_CLEAR: cell_d = '0;
            OP_MAC: begin
                cell_d.a   = a_in;
                cell_d.b   = b_in;
                cell_d.acc = cell_q.acc + ACC_W'(prod);
            end
            OP_SHIFT: cell_d.acc = acc_in;
            default:  cell_d = cell_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cell_q <= '0;
        end else begin
            cell_q <= cell_d;
        end
    end

    assign a_out   = cell_q.a;
    assign b_out   = cell_q.b;
    assign acc_out = cell_q.acc;

endmodule

// File: rtl/sa_matmul.sv
module sa_matmul
    import sa_pkg::*;
#(
    parameter  int N     = 4,
    parameter  int W     = 8,
    localparam int ACC_W = 2*W + $clog2(N)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [N*N*W-1:0]   a_flat,
    input  logic [N*N*W-1:0]   b_flat,
    output logic [N*ACC_W-1:0] res_row,
    output logic               res_valid,
    output logic               done
);

    localparam int CNT_W = $clog2(3*N);
    localparam logic [CNT_W-1:0] LAST_CALC  = CNT_W'(3*N - 3);
    localparam logic [CNT_W-1:0] LAST_DRAIN = CNT_W'(N - 1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
    } ctl_t;

    ctl_t     ctl_d, ctl_q;
    logic     accept;
    cell_op_e op;

    always_comb begin
        ctl_d  = ctl_q;
        accept = 1'b0;
        op     = OP_HOLD;
        unique case (ctl_q.phase)
            PH_IDLE: begin
                if (start) begin
                    accept      = 1'b1;
                    op          = OP_CLEAR;
                    ctl_d.phase = PH_CALC;
                    ctl_d.cnt   = '0;
                end
            end
            PH_CALC: begin
                op = OP_MAC;
                if (ctl_q.cnt == LAST_CALC) begin
                    ctl_d.phase = PH_DRAIN;
                    ctl_d.cnt   = '0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            PH_DRAIN: begin
                op = OP_SHIFT;
                if (ctl_q.cnt == LAST_DRAIN) begin
                    ctl_d.phase = PH_DONE;
                    ctl_d.cnt   = '0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            default: ctl_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{phase: PH_IDLE, cnt: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // Edge streams
    logic [W-1:0]   a_edge [N];
    logic [W-1:0]   b_edge [N];
    logic [N*W-1:0] b_col  [N];

    always_comb begin
        for (int j = 0; j < N; j++) begin
            for (int k = 0; k < N; k++) begin
                b_col[j][k*W +: W] = b_flat[(k*N + j)*W +: W];
            end
        end
    end

    for (genvar l = 0; l < N; l++) begin : g_feed
        sa_feeder #(.N(N), .W(W), .LANE(l), .CNT_W(CNT_W)) a_feed_i (
            .clk(clk), .rst_n(rst_n), .load(accept),
            .vec_in(a_flat[l*N*W +: N*W]), .step(ctl_q.cnt),
            .lane_out(a_edge[l])
        );
        sa_feeder #(.N(N), .W(W), .LANE(l), .CNT_W(CNT_W)) b_feed_i (
            .clk(clk), .rst_n(rst_n), .load(accept),
            .vec_in(b_col[l]), .step(ctl_q.cnt),
            .lane_out(b_edge[l])
        );
    end

    // Mesh
    logic signed [W-1:0]     a_h   [N][N];
    logic signed [W-1:0]     b_v   [N][N];
    logic signed [ACC_W-1:0] acc_m [N][N];

    for (genvar i = 0; i < N; i++) begin : g_row
        for (genvar j = 0; j < N; j++) begin : g_col
            logic signed [W-1:0]     a_src, b_src;
            logic signed [ACC_W-1:0] acc_src;
            if (j == 0) begin : g_left
                assign a_src = a_edge[i];
            end else begin : g_inner_a
                assign a_src = a_h[i][j-1];
            end
            if (i == 0) begin : g_top
                assign b_src   = b_edge[j];
                assign acc_src = '0;
            end else begin : g_inner_b
                assign b_src   = b_v[i-1][j];
                assign acc_src = acc_m[i-1][j];
            end
            sa_cell #(.W(W), .ACC_W(ACC_W)) cell_i (
                .clk(clk), .rst_n(rst_n), .op(op),
                .a_in(a_src), .b_in(b_src), .acc_in(acc_src),
                .a_out(a_h[i][j]), .b_out(b_v[i][j]), .acc_out(acc_m[i][j])
            );
        end
    end

    for (genvar j = 0; j < N; j++) begin : g_out
        assign res_row[j*ACC_W +: ACC_W] = acc_m[N-1][j];
    end

    assign res_valid = (ctl_q.phase == PH_DRAIN);
    assign done      = (ctl_q.phase == PH_DONE);

endmodule

// File: rtl/sa_matmul_chk.sv
module sa_matmul_chk #(
    parameter int N = 4
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic res_valid,
    input logic done
);

    logic busy_q;
    int   lat_q;
    int   run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            lat_q  <= 0;
            run_q  <= 0;
        end else begin
            if (!busy_q && start) begin
                busy_q <= 1'b1;
                lat_q  <= 0;
            end else if (busy_q && done) begin
                busy_q <= 1'b0;
            end else if (busy_q) begin
                lat_q <= lat_q + 1;
            end
            run_q <= res_valid ? run_q + 1 : 0;
        end
    end

    // R3
    first_row_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_valid) |-> (lat_q == 3*N - 2));

    // R4
    drain_len_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (run_q < N));

    // R4
    drain_len_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_q == N));

    // R5
    done_after_rows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(res_valid) && !res_valid);

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !res_valid);

    // R7
    output_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid || done) |-> busy_q);

endmodule

bind sa_matmul sa_matmul_chk #(.N(N)) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .res_valid(res_valid), .done(done)
);

// File: tb/sa_matmul_tb.sv
`timescale 1ns/1ps
module sa_matmul_tb_top;

    localparam int N     = 4;
    localparam int W     = 8;
    localparam int ACC_W = 2*W + $clog2(N);
    localparam int MW    = N*N*W;
    localparam int FIRST = 3*N - 1;   // negedge index of first valid row
    localparam int DONEK = FIRST + N; // negedge index of done

    typedef struct packed {
        logic [MW-1:0] a;
        logic [MW-1:0] b;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{a: 128'h01000000000100000000010000000001, b: 128'h0102030405060708F9FAFBFC7F80FF00},
        '{a: {16{8'h80}},                          b: {16{8'h80}}},                           // R9
        '{a: {16{8'h7F}},                          b: {16{8'h80}}},                           // R9
        '{a: 128'hFF01FE02FD03FC04FB05FA06F907F808, b: 128'h11223344556677889900AABBCCDDEEFF},
        '{a: {16{8'h7F}},                          b: {16{8'h7F}}},
        '{a: {16{8'h00}},                          b: 128'h0102030405060708090A0B0C0D0E0F10}
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [MW-1:0]      a_flat = '0;
    logic [MW-1:0]      b_flat = '0;
    logic [N*ACC_W-1:0] res_row;
    logic               res_valid;
    logic               done;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sa_matmul #(.N(N), .W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .a_flat(a_flat), .b_flat(b_flat),
        .res_row(res_row), .res_valid(res_valid), .done(done)
    );

    function automatic int ref_elem(logic [MW-1:0] a, logic [MW-1:0] b, int i, int j);
        int s = 0;
        for (int k = 0; k < N; k++) begin
            s += int'($signed(a[(i*N + k)*W +: W])) * int'($signed(b[(k*N + j)*W +: W]));
        end
        return s;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One multiplication; disturb injects a late start and operand changes (R7, R8)
    task automatic run_mult(input logic [MW-1:0] a, input logic [MW-1:0] b, input bit disturb);
        @(negedge clk);
        a_flat = a;
        b_flat = b;
        start  = 1'b1;
        for (int k = 1; k <= DONEK + 1; k++) begin
            @(negedge clk);
            if (k == 1) begin
                start = 1'b0;
                if (disturb) begin
                    a_flat = ~a;   // R8
                    b_flat = ~b;
                end
            end
            if (disturb && k == 4)         start = 1'b1;   // R7
            if (disturb && k == 5)         start = 1'b0;
            if (disturb && k == FIRST + 1) start = 1'b1;   // R7 during drain
            if (disturb && k == FIRST + 2) start = 1'b0;
            if (disturb && k == DONEK)     start = 1'b1;   // R7 in done cycle
            if (k == DONEK + 1)            start = 1'b0;
            // R3 R4: valid window position
            check(res_valid == (k >= FIRST && k < DONEK), "R3/R4 valid", int'(res_valid),
                  int'(k >= FIRST && k < DONEK));
            // R5: done pulse position
            check(done == (k == DONEK), "R5 done", int'(done), int'(k == DONEK));
            if (res_valid && k >= FIRST && k < DONEK) begin
                for (int j = 0; j < N; j++) begin
                    int exp_v = ref_elem(a, b, N - 1 - (k - FIRST), j);
                    int act_v = int'($signed(res_row[j*ACC_W +: ACC_W]));
                    // R2 R4 R6 R8 R9: value and row order
                    check(act_v == exp_v, "R2 row value", act_v, exp_v);
                end
            end
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        check(res_valid == 1'b0, "R1 valid in reset", int'(res_valid), 0);
        check(done == 1'b0, "R1 done in reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(res_valid == 1'b0, "R1 valid idle", int'(res_valid), 0);
        check(done == 1'b0, "R1 done idle", int'(done), 0);
        check(res_row == '0, "R1 row zero", int'(res_row[ACC_W-1:0]), 0);

        foreach (VECS[v]) begin
            run_mult(VECS[v].a, VECS[v].b, 1'b0);
        end

        // R9 explicit extremes
        run_mult({16{8'h80}}, {16{8'h80}}, 1'b0);
        check(ref_elem({16{8'h80}}, {16{8'h80}}, 0, 0) == N * (1 << (2*W - 2)),
              "R9 reference", ref_elem({16{8'h80}}, {16{8'h80}}, 0, 0), N * (1 << (2*W - 2)));

        // R7 R8: disturbed runs with random operands; R6: back-to-back runs
        for (int r = 0; r < 6; r++) begin
            logic [MW-1:0] ra, rb;
            for (int q = 0; q < MW/32; q++) begin
                ra[q*32 +: 32] = $urandom();
                rb[q*32 +: 32] = $urandom();
            end
            run_mult(ra, rb, r[0]);
        end

        // R7: idle with no start stays quiet
        repeat (8) begin
            @(negedge clk);
            check(!res_valid && !done, "R7 idle quiet", int'(res_valid | done), 0);
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule